// File: doc/BRIEF.md
# Bus Access Timeout Monitor

This block sits beside a simple request/ready register bus, between one or more masters and one peripheral register region. It counts the clock cycles in which a request is outstanding and the peripheral has not yet answered. When that count reaches a programmable threshold, the block does three things. It raises a sticky interrupt. It records the full address of the stalled access and a 7-bit identity tag of the master that issued it. It releases the bus by returning ready together with an error flag to the master for one cycle.

Software works the block through a small register port with write strobe, select and write data, and a combinational read path. The control register holds the threshold, the protection enable and a write-one-to-clear strobe for the interrupt. Two read-only registers return the captured address and the captured tag. To cover several peripheral regions, one instance is placed in front of each region.

Top module: `bus_timeout_monitor`

## Requirements
- R1: After reset the threshold is 65535, protection is enabled, the interrupt is low, both capture registers read 0 and the master sees neither ready nor error from the block.
- R2: With protection enabled and threshold T (T >= 1), a request that is held without peripheral ready for T consecutive cycles leads, in the next cycle, to one cycle of mst_ready_o=1 with mst_err_o=1. The interrupt rises in that same cycle.
- R3: The stall counter restarts from zero whenever no access is outstanding, so stalls shorter than T cycles never time out, even when they come back to back.
- R4: When the protection enable (control bit 17) is 0, no timeout is detected and a stall of any length ends only when the peripheral answers.
- R5: A threshold of 0 behaves like a threshold of 1. An idle bus never raises the interrupt.
- R6: On a timeout with no interrupt pending, select 1 returns the 32-bit request address and select 2 returns the tag in bits [6:0], with the master ID in bits [4:0] and the permission level in bits [6:5]. The interrupt stays high until it is cleared.
- R7: Writing select 0 with bit 16 set clears the interrupt and sets the tag capture to 0, while the address capture keeps its value. A control write with bit 16 at 0 leaves the interrupt unchanged.
- R8: While the interrupt is pending, later timeouts still release the bus but do not overwrite the address or tag captures.
- R9: If a clear write and a new timeout fall in the same cycle, the interrupt stays set and the new access's address and tag are captured.
- R10: Select 0 reads back the threshold in bits [15:0] and the enable in bit 17, and bit 16 always reads 0. Select 3 reads 0.
- R11: Outside the release cycle, mst_ready_o follows the peripheral ready and mst_err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Monitored bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | A master access is requested |
| req_addr_i | input | 32 | Address of the requested access |
| req_mid_i | input | 5 | Identifier of the requesting master |
| req_perm_i | input | 2 | Permission level of the requesting master |
| per_ready_i | input | 1 | Peripheral completes the access |
| mst_ready_o | output | 1 | Ready returned to the master |
| mst_err_o | output | 1 | Error flag returned with a forced release |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 2 | Register select: 0 control, 1 address, 2 tag |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for the current select |
| irq_o | output | 1 | Sticky timeout interrupt |

## Verification
A stall counter that drifts shows up as a release pulse in the wrong cycle: the error flag appears one or more cycles before or after the expected cycle T, or it appears on a stall that should have completed normally. Faults in the capture and interrupt logic become visible in the cycle after the timeout, in the select 1 and select 2 read values and on irq_o. The bench compares each of these against a model that is updated per access. A clear that hits the wrong field, or that loses against a simultaneous timeout in the wrong direction, shows up on the first read-back after the clear write.

// File: rtl/btm_pkg.sv
package btm_pkg;

    // Register select codes of the configuration port
    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ADDR = 2'd1,
        SEL_TAG  = 2'd2,
        SEL_NONE = 2'd3
    } btm_sel_e;

    // Reset defaults
    localparam logic RST_PROT_EN = 1'b1;

endpackage

// File: rtl/btm_regs.sv
module btm_regs
    import btm_pkg::*;
#(
    parameter int THR_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [1:0]        sel_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] cap_addr_i,
    input  logic [TAG_W-1:0]  cap_tag_i,
    output logic [THR_W-1:0]  thr_o,
    output logic              en_o,
    output logic              clr_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int CLR_BIT = THR_W;
    localparam int EN_BIT  = THR_W + 1;

    typedef struct packed {
        logic [THR_W-1:0] thr;
        logic             en;
    } regs_t;

    regs_t st_d, st_q;
    logic  ctrl_wr;

    always_comb begin
        st_d    = st_q;
        ctrl_wr = wr_i && (btm_sel_e'(sel_i) == SEL_CTRL);
        if (ctrl_wr) begin
            st_d.thr = wdata_i[THR_W-1:0];
            st_d.en  = wdata_i[EN_BIT];
        end
        clr_o = ctrl_wr && wdata_i[CLR_BIT];

        rdata_o = '0;
        case (btm_sel_e'(sel_i))
            SEL_CTRL: begin
                rdata_o[THR_W-1:0] = st_q.thr;
                rdata_o[EN_BIT]    = st_q.en;
            end
            SEL_ADDR: rdata_o[ADDR_W-1:0] = cap_addr_i;
            SEL_TAG:  rdata_o[TAG_W-1:0]  = cap_tag_i;
            default:  rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.thr <= '1;
            st_q.en  <= RST_PROT_EN;
        end else begin
            st_q <= st_d;
        end
    end

    assign thr_o = st_q.thr;
    assign en_o  = st_q.en;

endmodule

// File: rtl/btm_stall_counter.sv
module btm_stall_counter #(
    parameter int THR_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             req_i,
    input  logic             ready_i,
    input  logic             en_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             fire_o,
    output logic             abort_o
);

    localparam int CNT_W = THR_W + 1;

    typedef struct packed {
        logic [THR_W-1:0] cnt;
        logic             abort;
    } cnt_t;

    cnt_t             st_d, st_q;
    logic             pending;
    logic [CNT_W-1:0] eff_thr;
    logic [CNT_W-1:0] seen;

    always_comb begin
        st_d    = st_q;
        // A threshold of zero acts as one cycle
        eff_thr = (thr_i == '0) ? CNT_W'(1) : {1'b0, thr_i};
        pending = req_i && !ready_i && !st_q.abort;
        seen    = {1'b0, st_q.cnt} + CNT_W'(1);
        fire_o  = en_i && pending && (seen >= eff_thr);

        st_d.abort = fire_o;
        if (en_i && pending && !fire_o) begin
            st_d.cnt = st_q.cnt + THR_W'(1);
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign abort_o = st_q.abort;

endmodule

// File: rtl/btm_capture.sv
module btm_capture #(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 5,
    parameter int PERM_W = 2,
    parameter int TAG_W  = ID_W + PERM_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fire_i,
    input  logic              clr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ID_W-1:0]   mid_i,
    input  logic [PERM_W-1:0] perm_i,
    output logic              irq_o,
    output logic [ADDR_W-1:0] cap_addr_o,
    output logic [TAG_W-1:0]  cap_tag_o
);

    typedef struct packed {
        logic              irq;
        logic [ADDR_W-1:0] addr;
        logic [TAG_W-1:0]  tag;
    } cap_t;

    cap_t st_d, st_q;
    logic take;

    always_comb begin
        st_d = st_q;
        // A new timeout is stored when nothing is pending or a clear coincides
        take = fire_i && (!st_q.irq || clr_i);
        if (take) begin
            st_d.irq  = 1'b1;
            st_d.addr = addr_i;
            st_d.tag  = {perm_i, mid_i};
        end else if (clr_i) begin
            st_d.irq = 1'b0;
            st_d.tag = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o      = st_q.irq;
    assign cap_addr_o = st_q.addr;
    assign cap_tag_o  = st_q.tag;

endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor #(
    parameter int ADDR_W = 32,
    parameter int ID_W   = 5,
    parameter int PERM_W = 2,
    parameter int THR_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [ID_W-1:0]   req_mid_i,
    input  logic [PERM_W-1:0] req_perm_i,
    input  logic              per_ready_i,
    output logic              mst_ready_o,
    output logic              mst_err_o,
    input  logic              cfg_wr_i,
    input  logic [1:0]        cfg_sel_i,
    input  logic [DATA_W-1:0] cfg_wdata_i,
    output logic [DATA_W-1:0] cfg_rdata_o,
    output logic              irq_o
);

    localparam int TAG_W = ID_W + PERM_W;

    logic [THR_W-1:0]  thr;
    logic              prot_en;
    logic              clr;
    logic              fire;
    logic              abort;
    logic [ADDR_W-1:0] cap_addr;
    logic [TAG_W-1:0]  cap_tag;

    btm_regs #(
        .THR_W (THR_W),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W),
        .TAG_W (TAG_W)
    ) i_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_i      (cfg_wr_i),
        .sel_i     (cfg_sel_i),
        .wdata_i   (cfg_wdata_i),
        .cap_addr_i(cap_addr),
        .cap_tag_i (cap_tag),
        .thr_o     (thr),
        .en_o      (prot_en),
        .clr_o     (clr),
        .rdata_o   (cfg_rdata_o)
    );

    btm_stall_counter #(
        .THR_W(THR_W)
    ) i_counter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .req_i  (req_valid_i),
        .ready_i(per_ready_i),
        .en_i   (prot_en),
        .thr_i  (thr),
        .fire_o (fire),
        .abort_o(abort)
    );

    btm_capture #(
        .ADDR_W(ADDR_W),
        .ID_W  (ID_W),
        .PERM_W(PERM_W),
        .TAG_W (TAG_W)
    ) i_capture (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fire_i    (fire),
        .clr_i     (clr),
        .addr_i    (req_addr_i),
        .mid_i     (req_mid_i),
        .perm_i    (req_perm_i),
        .irq_o     (irq_o),
        .cap_addr_o(cap_addr),
        .cap_tag_o (cap_tag)
    );

    assign mst_ready_o = per_ready_i | abort;
    assign mst_err_o   = abort;

endmodule

// File: rtl/btm_checker.sv
module btm_checker #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 7
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              req_valid_i,
    input logic              per_ready_i,
    input logic [ADDR_W-1:0] req_addr_i,
    input logic              mst_ready_o,
    input logic              mst_err_o,
    input logic              irq_o,
    input logic              prot_en,
    input logic              clr,
    input logic              fire,
    input logic [ADDR_W-1:0] cap_addr,
    input logic [TAG_W-1:0]  cap_tag
);

    p_err_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mst_err_o |=> !mst_err_o);

    p_err_with_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mst_err_o |-> mst_ready_o);

    p_err_needs_stall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mst_err_o |-> $past(prot_en && req_valid_i && !per_ready_i));

    p_irq_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !clr) |=> irq_o);

    p_capture_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !clr) |=> ($stable(cap_addr) && $stable(cap_tag)));

    p_clear_wipes_tag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr && !fire) |=> (!irq_o && cap_tag == '0));

    p_new_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fire && (clr || !irq_o)) |=> (irq_o && cap_addr == $past(req_addr_i)));

endmodule

bind bus_timeout_monitor btm_checker #(
    .ADDR_W(ADDR_W),
    .TAG_W (TAG_W)
) i_btm_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .per_ready_i(per_ready_i),
    .req_addr_i (req_addr_i),
    .mst_ready_o(mst_ready_o),
    .mst_err_o  (mst_err_o),
    .irq_o      (irq_o),
    .prot_en    (prot_en),
    .clr        (clr),
    .fire       (fire),
    .cap_addr   (cap_addr),
    .cap_tag    (cap_tag)
);

// File: tb/test_bus_timeout_monitor.sv
module test_bus_timeout_monitor;

    localparam int CLK_PERIOD = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_addr_i = '0;
    logic [4:0]  req_mid_i = '0;
    logic [1:0]  req_perm_i = '0;
    logic        per_ready_i = 1'b0;
    logic        mst_ready_o;
    logic        mst_err_o;
    logic        cfg_wr_i = 1'b0;
    logic [1:0]  cfg_sel_i = '0;
    logic [31:0] cfg_wdata_i = '0;
    logic [31:0] cfg_rdata_o;
    logic        irq_o;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Reference model state
    logic [15:0] m_thr;
    bit          m_en;
    bit          m_irq;
    logic [31:0] m_addr;
    logic [6:0]  m_tag;

    bus_timeout_monitor i_bus_timeout_monitor (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_valid_i(req_valid_i),
        .req_addr_i (req_addr_i),
        .req_mid_i  (req_mid_i),
        .req_perm_i (req_perm_i),
        .per_ready_i(per_ready_i),
        .mst_ready_o(mst_ready_o),
        .mst_err_o  (mst_err_o),
        .cfg_wr_i   (cfg_wr_i),
        .cfg_sel_i  (cfg_sel_i),
        .cfg_wdata_i(cfg_wdata_i),
        .cfg_rdata_o(cfg_rdata_o),
        .irq_o      (irq_o)
    );

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    function automatic int eff_thr(input logic [15:0] t);
        return (t == 16'd0) ? 1 : int'(t);
    endfunction

    function automatic logic [31:0] ctrl_word(input logic [15:0] t, input bit en, input bit clr);
        return {14'd0, en, clr, t};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [15:0] t, input bit en, input bit clr);
        @(negedge clk_i);
        cfg_wr_i    = 1'b1;
        cfg_sel_i   = 2'd0;
        cfg_wdata_i = ctrl_word(t, en, clr);
        @(negedge clk_i);
        cfg_wr_i = 1'b0;
        m_thr = t;
        m_en  = en;
        if (clr) begin
            m_irq = 1'b0;
            m_tag = '0;
        end
    endtask

    task automatic read_chk(input logic [1:0] sel, input logic [31:0] exp, input string req);
        @(negedge clk_i);
        cfg_sel_i = sel;
        #1;
        chk(cfg_rdata_o == exp, req, cfg_rdata_o, exp);
    endtask

    task automatic check_state(input string req);
        #1;
        chk(irq_o == m_irq, {req, " irq"}, 32'(irq_o), 32'(m_irq));
        read_chk(2'd1, m_addr, {req, " addr"});
        read_chk(2'd2, 32'(m_tag), {req, " tag"});
    endtask

    // One access held for len cycles before the peripheral answers
    task automatic stall(input logic [31:0] addr, input logic [4:0] mid, input logic [1:0] perm,
                         input int len, input bit clr_at_fire, input string req);
        int  t;
        bit  to;
        int  last;
        t    = eff_thr(m_thr);
        to   = m_en && (len >= t);
        last = to ? t : len;
        for (int c = 0; c <= last; c++) begin
            @(negedge clk_i);
            req_valid_i = 1'b1;
            req_addr_i  = addr;
            req_mid_i   = mid;
            req_perm_i  = perm;
            per_ready_i = (!to && c == len);
            cfg_wr_i    = clr_at_fire && to && (c == t - 1);
            cfg_sel_i   = 2'd0;
            cfg_wdata_i = ctrl_word(m_thr, m_en, 1'b1);
            #1;
            chk(mst_ready_o == (c == last), {req, " ready"}, 32'(mst_ready_o), 32'(c == last));
            chk(mst_err_o == (to && c == last), {req, " err"}, 32'(mst_err_o), 32'(to && c == last));
        end
        @(negedge clk_i);
        req_valid_i = 1'b0;
        per_ready_i = 1'b0;
        cfg_wr_i    = 1'b0;
        if (to) begin
            if (!m_irq || clr_at_fire) begin
                m_addr = addr;
                m_tag  = {perm, mid};
            end
            m_irq = 1'b1;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        m_thr = 16'hFFFF; m_en = 1'b1; m_irq = 1'b0; m_addr = '0; m_tag = '0;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;

        // R1 reset state
        #1;
        chk(irq_o == 1'b0, "R1 irq", 32'(irq_o), 0);
        chk(mst_ready_o == 1'b0 && mst_err_o == 1'b0, "R1 bus", {mst_ready_o, mst_err_o}, 0);
        read_chk(2'd0, 32'h0002_FFFF, "R1 ctrl");
        read_chk(2'd1, 0, "R1 addr");
        read_chk(2'd2, 0, "R1 tag");
        read_chk(2'd3, 0, "R10 unused select");

        // R10 readback, clear bit reads 0
        cfg_write(16'd5, 1'b1, 1'b0);
        read_chk(2'd0, ctrl_word(16'd5, 1'b1, 1'b0), "R10 ctrl");

        // R3 short back-to-back stalls, R11 passthrough
        stall(32'h1000_0004, 5'd1, 2'd0, 4, 1'b0, "R3 short");
        stall(32'h1000_0008, 5'd1, 2'd0, 4, 1'b0, "R11 short");
        check_state("R3 no irq");

        // R2 timeout, R6 capture
        stall(32'hDEAD_BEE0, 5'd19, 2'd2, 10, 1'b0, "R2 timeout");
        check_state("R6 capture");

        // R8 no overwrite while pending
        stall(32'h0BAD_0010, 5'd7, 2'd1, 10, 1'b0, "R8 second");
        check_state("R8 held");

        // R7 write with clear bit 0 has no effect, then clear
        cfg_write(16'd5, 1'b1, 1'b0);
        check_state("R7 no-op write");
        cfg_write(16'd5, 1'b1, 1'b1);
        check_state("R7 cleared");

        // R4 protection disabled
        cfg_write(16'd5, 1'b0, 1'b0);
        stall(32'h2000_0000, 5'd2, 2'd3, 30, 1'b0, "R4 disabled");
        check_state("R4 no irq");

        // R5 threshold zero; idle bus never fires
        cfg_write(16'd0, 1'b1, 1'b0);
        repeat (5) @(negedge clk_i);
        check_state("R5 idle");
        stall(32'h3000_0030, 5'd31, 2'd3, 3, 1'b0, "R5 thr0");
        check_state("R5 capture");

        // R9 clear and timeout in the same cycle
        cfg_write(16'd4, 1'b1, 1'b0);
        stall(32'h4444_0040, 5'd9, 2'd1, 10, 1'b1, "R9 clash");
        check_state("R9 new wins");

        // Random mix
        for (int k = 0; k < 40; k++) begin
            logic [15:0] t;
            bit          en;
            t  = 16'($urandom_range(12, 0));
            en = ($urandom_range(9, 0) != 0);
            cfg_write(t, en, ($urandom_range(3, 0) == 0));
            stall($urandom, 5'($urandom), 2'($urandom), $urandom_range(20, 0),
                  1'b0, "R2 random");
            check_state("R6 random");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule